// File: doc/BRIEF.md
# Programmable-Step Up/Down Counter

This block keeps a 16-bit unsigned count that moves only on the rising edge of its clock. At each edge it chooses one of four actions: clear the count to zero, take a preset value, add a step value, or subtract that step value. The step is a runtime input, so software or a neighbouring block can change the increment from one edge to the next. Arithmetic wraps modulo 2^16, and there is no carry or borrow output.

The clear, load and direction controls are full-width buses, and only their least significant bit has any effect. This lets them be wired straight from wide control words. A separate synchronous active-low reset puts the count at a power-up value chosen by parameter. When several controls are asserted on the same edge, clear has the highest priority, then load, then counting.

Top module: `step_counter`

## Requirements
- R1: The count changes only on a rising clock edge. Changes to any data or control input between edges leave `count_o` unchanged until the next rising edge.
- R2: When bit 0 of `clear_i` is 1 at a rising edge (and `rst_n` is 1), the count becomes 0, whatever the values of load and direction.
- R3: When bit 0 of `clear_i` is 0 and bit 0 of `load_i` is 1 at a rising edge, the count takes the value of `preset_i`, whatever the value of direction.
- R4: When bit 0 of `clear_i` and bit 0 of `load_i` are both 0 and bit 0 of `dir_i` is 1, the count becomes (count + `step_i`) mod 2^16.
- R5: When bit 0 of `clear_i`, `load_i` and `dir_i` are all 0, the count becomes (count − `step_i`) mod 2^16. A step of 0 leaves the count unchanged.
- R6: When `rst_n` is 0 at a rising edge, the count becomes the parameter `INIT_VAL` (default 16'h1234). This overrides clear, load and counting.
- R7: Bits 1 and above of `clear_i`, `load_i` and `dir_i` have no effect on the count.
- R8: Adding or subtracting a step greater than 1 past either end of the range wraps silently. For example, 16'hFFFE + 5 gives 16'h0003, and 16'h0003 − 7 gives 16'hFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; the count changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to `INIT_VAL` |
| clear_i | input | 16 | Clear control; only bit 0 is used |
| load_i | input | 16 | Load control; only bit 0 is used |
| dir_i | input | 16 | Direction; bit 0 = 1 adds, bit 0 = 0 subtracts |
| preset_i | input | 16 | Value taken on a load |
| step_i | input | 16 | Amount added or subtracted per counting edge |
| count_o | output | 16 | Current count |

## Verification
The properties assume that every input is stable and known at each rising edge and that `rst_n` is held low for at least one edge before counting starts. The expected next count is then fully determined by the previous count and the sampled inputs. The bench meets these assumptions by changing inputs only on falling edges and by starting with two reset edges. It also places deliberately mixed upper bits on the control buses, which the properties treat as don't-care. Some patterns set clear, load and direction on the same edge, so the priority ordering is exercised while the inputs still stay within these assumptions.

// File: rtl/step_counter_pkg.sv
// Shared types for the programmable-step counter.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package step_counter_pkg;

    // Action chosen for the next rising edge, highest priority first.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_UP    = 2'd2,
        ACT_DOWN  = 2'd3
    } act_e;

endpackage

// File: rtl/step_counter_decode.sv
// Priority decoder: turns the least significant bit of the clear, load and
// direction buses into a single action code (clear > load > up/down).
// Assumes: upper control bits carry no meaning and are dropped here.
module step_counter_decode
    import step_counter_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic [CTRL_W-1:0] clear_i,
    input  logic [CTRL_W-1:0] load_i,
    input  logic [CTRL_W-1:0] dir_i,
    output act_e              act_o
);

    // Upper control bits are folded together only so they are visibly consumed.
    generate
        if (CTRL_W > 1) begin : g_wide
            logic ctrl_unused;
            assign ctrl_unused = ^{clear_i[CTRL_W-1:1], load_i[CTRL_W-1:1], dir_i[CTRL_W-1:1]};
        end
    endgenerate

    // Resolve the fixed priority among the three control bits.
    always_comb begin
        if (clear_i[0])     act_o = ACT_CLEAR;
        else if (load_i[0]) act_o = ACT_LOAD;
        else if (dir_i[0])  act_o = ACT_UP;
        else                act_o = ACT_DOWN;
    end

endmodule

// File: rtl/step_counter_arith.sv
// Step arithmetic: computes count + step or count - step, modulo 2^W.
// SHARED_ADDER = 1 builds one adder fed with the step or its complement;
// SHARED_ADDER = 0 builds a separate adder and subtractor and a final mux.
// Assumes: the result is truncated to W bits with no carry/borrow kept.
module step_counter_arith #(
    parameter int W            = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] step_i,
    input  logic         up_i,
    output logic [W-1:0] result_o
);

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [W-1:0] operand;
            logic [W-1:0] carry_in;
            // Two's-complement subtract: invert the step and inject a carry.
            always_comb begin
                operand  = up_i ? step_i : ~step_i;
                carry_in = {{(W-1){1'b0}}, ~up_i};
                result_o = count_i + operand + carry_in;
            end
        end else begin : g_split
            logic [W-1:0] sum;
            logic [W-1:0] diff;
            // Independent add and subtract, selected by direction.
            always_comb begin
                sum      = count_i + step_i;
                diff     = count_i - step_i;
                result_o = up_i ? sum : diff;
            end
        end
    endgenerate

endmodule

// File: rtl/step_counter_state.sv
// Count register with synchronous active-low reset to a parameterised value.
// Assumes: a single clock domain; next value is settled before each edge.
module step_counter_state #(
    parameter int           W        = 16,
    parameter logic [W-1:0] INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] q_o
);

    // Hold the count; reset wins over any requested update.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= INIT_VAL;
        else        q_o <= next_i;
    end

endmodule

// File: rtl/step_counter.sv
// Programmable-step up/down counter top. On each rising edge the count is
// cleared, loaded, or moved by step_i, in that priority order.
// Assumes: inputs are synchronous to clk; only bit 0 of each control bus counts.
module step_counter
    import step_counter_pkg::*;
#(
    parameter int           W            = 16,
    parameter int           CTRL_W       = 16,
    parameter logic [W-1:0] INIT_VAL     = 16'h1234,
    parameter bit           SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] clear_i,
    input  logic [CTRL_W-1:0] load_i,
    input  logic [CTRL_W-1:0] dir_i,
    input  logic [W-1:0]      preset_i,
    input  logic [W-1:0]      step_i,
    output logic [W-1:0]      count_o
);

    act_e         act;
    logic [W-1:0] moved;
    logic [W-1:0] next_count;

    step_counter_decode #(.CTRL_W(CTRL_W)) u_decode (
        .clear_i (clear_i),
        .load_i  (load_i),
        .dir_i   (dir_i),
        .act_o   (act)
    );

    step_counter_arith #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_arith (
        .count_i  (count_o),
        .step_i   (step_i),
        .up_i     (act == ACT_UP),
        .result_o (moved)
    );

    // Pick the next count from the decoded action.
    always_comb begin
        unique case (act)
            ACT_CLEAR: next_count = '0;
            ACT_LOAD:  next_count = preset_i;
            default:   next_count = moved;
        endcase
    end

    step_counter_state #(.W(W), .INIT_VAL(INIT_VAL)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (next_count),
        .q_o    (count_o)
    );

endmodule

// File: rtl/step_counter_checker.sv
// Property checker for step_counter, attached by bind below.
// Assumes: inputs are known at every rising edge once reset has been applied.
module step_counter_checker #(
    parameter int           W        = 16,
    parameter int           CTRL_W   = 16,
    parameter logic [W-1:0] INIT_VAL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] clear_i,
    input logic [CTRL_W-1:0] load_i,
    input logic [CTRL_W-1:0] dir_i,
    input logic [W-1:0]      preset_i,
    input logic [W-1:0]      step_i,
    input logic [W-1:0]      count_o
);

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i[0] |=> count_o == '0);

    a_r3_load_takes_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i[0] && load_i[0]) |=> count_o == $past(preset_i));

    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i[0] && !load_i[0] && dir_i[0]) |=> count_o == W'($past(count_o) + $past(step_i)));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i[0] && !load_i[0] && !dir_i[0]) |=> count_o == W'($past(count_o) - $past(step_i)));

    a_r6_reset_value: assert property (@(posedge clk)
        !rst_n |=> count_o == INIT_VAL);

endmodule

bind step_counter step_counter_checker #(
    .W(W), .CTRL_W(CTRL_W), .INIT_VAL(INIT_VAL)
) u_checker (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_i(load_i),
    .dir_i(dir_i), .preset_i(preset_i), .step_i(step_i), .count_o(count_o)
);

// File: tb/step_counter_bench.sv
module step_counter_bench;

    localparam logic [15:0] INIT = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] clear_i = '0, load_i = '0, dir_i = '0, preset_i = '0, step_i = '0;
    logic [15:0] count_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    step_counter u_step_counter (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_i(load_i),
        .dir_i(dir_i), .preset_i(preset_i), .step_i(step_i), .count_o(count_o)
    );

    // Fields: clear, load, dir, preset, step, expected count after the edge.
    localparam int NV = 12;
    localparam logic [95:0] VEC [NV] = '{
        {16'h0000, 16'h0001, 16'h0000, 16'h0100, 16'h0000, 16'h0100}, // R3 load
        {16'h0000, 16'h0000, 16'h8001, 16'h0000, 16'h0003, 16'h0103}, // R4 up
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0010, 16'h00F3}, // R5 down
        {16'h0001, 16'h0001, 16'h0001, 16'hAAAA, 16'h0009, 16'h0000}, // R2 clear over all
        {16'h0000, 16'h0001, 16'h0001, 16'hFFFE, 16'h0005, 16'hFFFE}, // R3 load over up
        {16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0005, 16'h0003}, // R8 wrap up
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0007, 16'hFFFC}, // R8 wrap down
        {16'h0001, 16'h0000, 16'h0000, 16'h7777, 16'h0004, 16'h0000}, // R2 clear over down
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R5 zero step
        {16'h0000, 16'hF001, 16'h0000, 16'h8000, 16'h0001, 16'h8000}, // R3 load over down
        {16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h8000, 16'h0000}, // R8 wrap at half
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 16'hFFFE}  // R8 borrow below zero
    };

    task automatic check(input logic [15:0] exp, input string req);
        checks++;
        if (count_o !== exp) begin
            failures++;
            $display("FAIL %s: count_o=%h expected=%h", req, count_o, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R6: reset to INIT_VAL
        step_edge();
        step_edge();
        check(INIT, "R6");

        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clear_i, load_i, dir_i, preset_i, step_i} = VEC[i][95:16];
            step_edge();
            check(VEC[i][15:0], $sformatf("vector %0d (R2/R3/R4/R5/R8)", i));
        end

        // R7: upper control bits set, bit 0 clear -> count down by step
        @(negedge clk);
        clear_i = 16'hFFFE; load_i = 16'hFFFE; dir_i = 16'hFFFE;
        preset_i = 16'h4444; step_i = 16'h0002;
        step_edge();
        check(16'hFFFC, "R7 down despite upper bits");

        // R7: upper bits set with dir bit 0 high -> count up
        @(negedge clk);
        dir_i = 16'hFFFF; step_i = 16'h0010;
        step_edge();
        check(16'h000C, "R7 up despite upper bits");

        // R1: mid-cycle input changes do not move the count
        @(negedge clk);
        load_i = 16'h0001; preset_i = 16'h5555;
        #2;
        check(16'h000C, "R1 hold between edges");
        step_edge();
        check(16'h5555, "R1 update at edge");

        // R6: reset overrides a pending load mid-run
        @(negedge clk);
        rst_n = 1'b0; load_i = 16'h0001; preset_i = 16'h9999;
        step_edge();
        check(INIT, "R6 reset over load");

        // R6/R3: counting resumes after release
        @(negedge clk);
        rst_n = 1'b1; load_i = '0; dir_i = 16'h0001; step_i = 16'h0100;
        step_edge();
        check(16'h1334, "R4 after reset release");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule